// File: doc/BRIEF.md
# Microinstruction-Driven ALU and Shifter

This block is the arithmetic stage of a horizontally microcoded datapath. One 32-bit operand comes from a holding register and the other from a source bus. An 8-bit control slice of the current microinstruction drives the unit. Six of those bits are raw control lines: a two-bit function select, a gate for each operand, an invert on the holding-register operand and a carry-in increment. Together they give sixteen useful operations, including pass, complement, add, subtract, increment, decrement, negate, AND, OR and the constants 0, 1 and −1. The other two bits send the result through a shifter. It can move the result left by one byte, which is used to place a high index or offset byte, or shift it right by one bit arithmetically.

The shifted result is a combinational output that feeds the destination bus. A negative flag and a zero flag are taken from the ALU output before the shifter and are captured on the rising clock edge. The microsequencer later uses them for conditional branches.

Top module: `alu_shift_unit`

## Requirements
- R1: The control byte `ctrl` is laid out from bit 7 down to bit 0 as: left-byte-shift, arithmetic-right-shift, F0, F1, operand-A enable, operand-B enable, invert-A, increment.
- R2: With {F0,F1} = 00 the ALU produces A AND B, and with 01 it produces A OR B.
- R3: With {F0,F1} = 10 the ALU produces the bitwise complement of B, and A has no effect.
- R4: With {F0,F1} = 11 the ALU produces A + B + increment in 32-bit two's complement, and any carry out of bit 31 is discarded.
- R5: When the A enable is 0, operand A is zero. When the B enable is 0, operand B is zero.
- R6: Invert-A complements operand A after its enable is applied, so a disabled A that is inverted reads as all ones.
- R7: With only the left-byte-shift bit set, `shift_out` is the ALU output moved left by 8 bits, with zeros in bits 7:0.
- R8: With only the arithmetic-right-shift bit set, `shift_out` is the ALU output moved right by 1 bit, with bit 31 kept.
- R9: With neither shift bit set, `shift_out` equals the ALU output.
- R10: At each rising edge out of reset, `flag_n` takes bit 31 of the unshifted ALU output.
- R11: At each rising edge out of reset, `flag_z` takes 1 exactly when the unshifted ALU output is zero.
- R12: A synchronous active-high `rst` clears both flags at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| ctrl | input | 8 | ALU and shifter control slice of the microinstruction |
| a_hold | input | 32 | Operand from the holding register |
| b_bus | input | 32 | Operand from the source bus |
| shift_out | output | 32 | Shifted ALU result |
| flag_n | output | 1 | Registered negative flag of the unshifted result |
| flag_z | output | 1 | Registered zero flag of the unshifted result |

## Verification
The checker assumes the microcode never sets both shift bits in the same cycle, because the output is undefined for that code. It flags any cycle that breaks this rule. The stimulus only applies control bytes with at most one shift bit set, and it holds `ctrl`, `a_hold` and `b_bus` steady across each sampling edge, so the flag properties compare against settled values. The shift properties are checked only for legal shift codes, and the reset property is checked only at edges where `rst` is sampled high.

// File: rtl/alu_shift_pkg.sv
package alu_shift_pkg;

  // Function select as {F0,F1}
  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_ADD  = 2'b11
  } alu_fn_e;

  // Field order of the control byte, MSB first
  typedef struct packed {
    logic    sll8;
    logic    sra1;
    alu_fn_e fn;
    logic    ena;
    logic    enb;
    logic    inva;
    logic    inc;
  } alu_ctrl_t;

  localparam int unsigned CTRL_W = $bits(alu_ctrl_t);

endpackage

// File: rtl/operand_gate.sv
module operand_gate #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_raw,
  input  logic [W-1:0] b_raw,
  input  logic         ena,
  input  logic         enb,
  input  logic         inva,
  output logic [W-1:0] a_op,
  output logic [W-1:0] b_op
);

  logic [W-1:0] a_gated;

  // Enable applies first, inversion after it
  always_comb begin
    a_gated = ena ? a_raw : '0;
    a_op    = inva ? ~a_gated : a_gated;
    b_op    = enb ? b_raw : '0;
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_shift_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alu_fn_e      fn,
  input  logic         inc,
  input  logic [W-1:0] a_op,
  input  logic [W-1:0] b_op,
  output logic [W-1:0] y
);

  logic [W:0] sum_ext;

  // Widened sum; the top bit (carry out) is dropped
  assign sum_ext = {1'b0, a_op} + {1'b0, b_op} + {{W{1'b0}}, inc};

  always_comb begin
    unique case (fn)
      FN_AND:  y = a_op & b_op;
      FN_OR:   y = a_op | b_op;
      FN_NOTB: y = ~b_op;
      default: y = sum_ext[W-1:0];
    endcase
  end

endmodule

// File: rtl/result_shifter.sv
module result_shifter #(
  parameter int unsigned W  = 32,
  parameter int unsigned SH = 8
) (
  input  logic         sll,
  input  logic         sra,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] left_val;
  logic [W-1:0] right_val;

  generate
    if (SH < W) begin : g_left
      assign left_val = {din[W-SH-1:0], {SH{1'b0}}};
    end else begin : g_left_all
      assign left_val = '0;
    end
  endgenerate

  assign right_val = {din[W-1], din[W-1:1]};

  // Both bits set is an illegal code; left shift wins as a don't-care
  always_comb begin
    unique case ({sll, sra})
      2'b00:   dout = din;
      2'b01:   dout = right_val;
      default: dout = left_val;
    endcase
  end

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
  import alu_shift_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned SH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [W-1:0]      a_hold,
  input  logic [W-1:0]      b_bus,
  output logic [W-1:0]      shift_out,
  output logic              flag_n,
  output logic              flag_z
);

  alu_ctrl_t    cw;
  logic [W-1:0] a_op;
  logic [W-1:0] b_op;
  logic [W-1:0] alu_y;

  assign cw = alu_ctrl_t'(ctrl);

  operand_gate #(.W(W)) u_gate (
    .a_raw (a_hold),
    .b_raw (b_bus),
    .ena   (cw.ena),
    .enb   (cw.enb),
    .inva  (cw.inva),
    .a_op  (a_op),
    .b_op  (b_op)
  );

  alu_core #(.W(W)) u_alu (
    .fn   (cw.fn),
    .inc  (cw.inc),
    .a_op (a_op),
    .b_op (b_op),
    .y    (alu_y)
  );

  result_shifter #(.W(W), .SH(SH)) u_shift (
    .sll  (cw.sll8),
    .sra  (cw.sra1),
    .din  (alu_y),
    .dout (shift_out)
  );

  // Flags come from the pre-shift value
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      flag_n <= alu_y[W-1];
      flag_z <= (alu_y == '0);
    end
  end

endmodule

// File: rtl/alu_shift_unit_chk.sv
module alu_shift_unit_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned SH = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [7:0]   ctrl,
  input logic [W-1:0] a_hold,
  input logic [W-1:0] b_bus,
  input logic [W-1:0] alu_y,
  input logic [W-1:0] shift_out,
  input logic         flag_n,
  input logic         flag_z
);

  AST_SHIFT_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    !(ctrl[7] && ctrl[6])); // R1

  AST_PLAIN_ADD_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (ctrl[5:0] == 6'b111100) |-> (alu_y == W'(a_hold + b_bus))); // R4

  AST_NO_SHIFT_PASS: assert property (@(posedge clk) disable iff (rst)
    (ctrl[7:6] == 2'b00) |-> (shift_out == alu_y)); // R9

  AST_LEFT_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctrl[7:6] == 2'b10) |-> (shift_out[SH-1:0] == '0)); // R7

  AST_RIGHT_KEEPS_SIGN: assert property (@(posedge clk) disable iff (rst)
    (ctrl[7:6] == 2'b01) |-> (shift_out[W-1] == alu_y[W-1])); // R8

  AST_NEG_FLAG_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (flag_n == $past(alu_y[W-1]))); // R10

  AST_ZERO_FLAG_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (flag_z == ($past(alu_y) == '0))); // R11

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!flag_n && !flag_z)); // R12

endmodule

bind alu_shift_unit alu_shift_unit_chk #(.W(W), .SH(SH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctrl      (ctrl),
  .a_hold    (a_hold),
  .b_bus     (b_bus),
  .alu_y     (alu_y),
  .shift_out (shift_out),
  .flag_n    (flag_n),
  .flag_z    (flag_z)
);

// File: tb/alu_shift_unit_test.sv
module alu_shift_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  typedef struct packed {
    logic [7:0]  c;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] y;
    logic        n;
    logic        z;
    logic [3:0]  req;
  } vec_t;

  // ctrl, A, B, expected shift_out, expected N, expected Z, requirement
  localparam vec_t VEC [NVEC] = '{
    '{8'h18, 32'h12345678, 32'h0F0F0F0F, 32'h12345678, 1'b0, 1'b0, 4'd1},
    '{8'h14, 32'h12345678, 32'h0F0F0F0F, 32'h0F0F0F0F, 1'b0, 1'b0, 4'd1},
    '{8'h1A, 32'h12345678, 32'h0F0F0F0F, 32'hEDCBA987, 1'b1, 1'b0, 4'd6},
    '{8'h2C, 32'h12345678, 32'h0F0F0F0F, 32'hF0F0F0F0, 1'b1, 1'b0, 4'd3},
    '{8'h3C, 32'h00000005, 32'h00000007, 32'h0000000C, 1'b0, 1'b0, 4'd4},
    '{8'h3D, 32'h00000005, 32'h00000007, 32'h0000000D, 1'b0, 1'b0, 4'd4},
    '{8'h39, 32'h7FFFFFFF, 32'h00001234, 32'h80000000, 1'b1, 1'b0, 4'd4},
    '{8'h35, 32'h00000055, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b1, 4'd4},
    '{8'h3F, 32'h00000009, 32'h00000004, 32'hFFFFFFFB, 1'b1, 1'b0, 4'd4},
    '{8'h36, 32'h00000077, 32'h00000000, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd6},
    '{8'h3B, 32'h00000001, 32'h00000099, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd6},
    '{8'h0C, 32'hFF00FF00, 32'h0FF00FF0, 32'h0F000F00, 1'b0, 1'b0, 4'd2},
    '{8'h1C, 32'hFF00FF00, 32'h0FF00FF0, 32'hFFF0FFF0, 1'b1, 1'b0, 4'd2},
    '{8'h10, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b1, 4'd5},
    '{8'h31, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0, 4'd5},
    '{8'h32, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd6},
    '{8'h98, 32'h000000AB, 32'h00000000, 32'h0000AB00, 1'b0, 1'b0, 4'd7},
    '{8'h98, 32'h80000001, 32'h00000000, 32'h00000100, 1'b1, 1'b0, 4'd10},
    '{8'h98, 32'h01000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 4'd11},
    '{8'h58, 32'h80000004, 32'h00000000, 32'hC0000002, 1'b1, 1'b0, 4'd8},
    '{8'h58, 32'h00000006, 32'h00000000, 32'h00000003, 1'b0, 1'b0, 4'd8},
    '{8'h58, 32'h00000001, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 4'd11},
    '{8'h72, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd8},
    '{8'h08, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b1, 4'd5},
    '{8'h16, 32'h12345678, 32'h00000001, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd6},
    '{8'h24, 32'hDEADBEEF, 32'h00000001, 32'hFFFFFFFE, 1'b1, 1'b0, 4'd3}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ctrl = 8'h00;
  logic [31:0] a_hold = '0;
  logic [31:0] b_bus = '0;
  logic [31:0] shift_out;
  logic        flag_n;
  logic        flag_z;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_shift_unit uut (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .a_hold    (a_hold),
    .b_bus     (b_bus),
    .shift_out (shift_out),
    .flag_n    (flag_n),
    .flag_z    (flag_z)
  );

  function automatic string req_name(input logic [3:0] k);
    case (k)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd10:   return "R10";
      4'd11:   return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s: got %08h expected %08h", tag, what, got, exp);
    end
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    // Reset state (R12)
    repeat (3) @(negedge clk);
    check("R12", "flag_n at reset", {31'b0, flag_n}, 32'd0);
    check("R12", "flag_z at reset", {31'b0, flag_z}, 32'd0);
    rst = 1'b0;

    // Table walk: result right after drive, flags one edge later
    for (int i = 0; i < NVEC; i++) begin
      ctrl   = VEC[i].c;
      a_hold = VEC[i].a;
      b_bus  = VEC[i].b;
      #1;
      check(req_name(VEC[i].req), "shift_out", shift_out, VEC[i].y);
      @(negedge clk);
      check((VEC[i].c[7:6] == 2'b00) ? "R10" : req_name(VEC[i].req),
            "flag_n", {31'b0, flag_n}, {31'b0, VEC[i].n});
      check("R11", "flag_z", {31'b0, flag_z}, {31'b0, VEC[i].z});
    end

    // R9: no shift bits, result unmodified (B passes with sign set)
    ctrl = 8'h14; a_hold = 32'h0; b_bus = 32'h80000001;
    #1;
    check("R9", "shift_out unshifted", shift_out, 32'h80000001);

    // R12: reset mid-run clears flags set by a -1 result
    ctrl = 8'h32; a_hold = '0; b_bus = '0;
    @(negedge clk);
    check("R10", "flag_n before reset", {31'b0, flag_n}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    check("R12", "flag_n after reset", {31'b0, flag_n}, 32'd0);
    ctrl = 8'h10;
    @(negedge clk);
    check("R12", "flag_z held in reset", {31'b0, flag_z}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R11", "flag_z after release", {31'b0, flag_z}, 32'd1);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule